// File: doc/BRIEF.md
# SDRAM Single-Bank Command Timing Guard

This block sits between a memory controller's command sequencer and one bank of a single-data-rate SDRAM. Each clock it is offered at most one command: row open, column read, column write, row close, or burst terminate. It forwards a command to the device pins only once every minimum spacing that applies to it has run out. Until then it holds the command back by keeping `cmd_ready` low. Commands that break the open/closed row protocol are consumed without being forwarded, and a one-cycle error pulse reports them. A sticky flag shows that a row has been left open longer than the allowed maximum.

All device timings are parameters given in nanoseconds, with the clock period given in picoseconds. At elaboration each is turned into a whole number of clocks. Every row and column spacing has its own down-counter, which the command that starts that spacing reloads. An optional relaxed write-recovery mode takes effect only when the clock period is 10 ns or longer. At any faster clock the strict values are used.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Every minimum delay in clocks is the nanosecond figure divided by the clock period, rounded up to the next whole clock. For example, 42 ns at a 4 ns clock gives 11 clocks.
- R2: A column read or write is accepted no sooner than tRCD clocks after the accepted row-open command.
- R3: A row-close command is accepted no sooner than tRAS-min clocks after the accepted row-open command.
- R4: Two accepted row-open commands are at least tRC clocks apart.
- R5: A row-open command is accepted no sooner than tRP clocks after the accepted row-close command.
- R6: A row-close command is accepted no sooner than BURST_LEN-1+tRDL clocks after the last accepted write. tRDL is 2 clocks in strict mode.
- R7: A row-open command is accepted no sooner than BURST_LEN-1+tDAL clocks after the last accepted write. tDAL is 2 clocks plus tRP in strict mode.
- R8: Relaxed mode applies only when it is requested and the clock period is at least 10 ns. It sets tRDL to 1 clock and tDAL to 1 clock plus ceil(20 ns / period). If relaxed mode is requested with a faster clock, the strict values are used.
- R9: Column commands (read, write) to an open row can be accepted on consecutive clocks.
- R10: A read or write offered while no row is open, or a row-open offered while a row is open, is handled as follows.
  - It is consumed at once (`cmd_ready` high).
  - It is not forwarded: `cmd_out` shows NOP on the next clock.
  - It does not change the row state or any timer.
  - `proto_err` is high for exactly the next clock.
- R11: `tras_violation` goes high if a row is still open more than tRAS-max clocks after its row-open command was accepted. It stays high until reset. Closing the row exactly tRAS-max clocks after opening it does not set the flag.
- R12: `cmd_out` is registered and uses these codes: NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, BURST STOP=5.
  - On the clock after an accepted command it carries that command's code; otherwise it carries NOP.
  - Codes 6 and 7 are accepted and forwarded as NOP.
  - After reset, `cmd_out` is NOP, both flags are low and a row-open command is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_code | input | 3 | Offered command code (see R12) |
| cmd_ready | output | 1 | Offered command is consumed at this clock edge |
| cmd_out | output | 3 | Registered command driven to the device |
| proto_err | output | 1 | One-cycle pulse: last consumed command broke the row protocol |
| tras_violation | output | 1 | Sticky: a row exceeded the maximum open time |

## Verification
The embedded properties check structural facts on every cycle:
- a forwarded column command always finds the row open, and a forwarded row-open finds it newly open;
- a protocol error always coincides with a NOP on the device pins;
- a spacing counter never counts up without a reload;
- the open-row age never passes its cap, and the overstay flag never drops.

The exact clock counts between accepted commands can only be shown by the directed scenarios, which measure grant-to-grant distances. These cover the rounding of nanosecond figures, which spacing dominates when several apply, the strict and relaxed write recovery, and the exact cycle in which the overstay flag rises.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    // spacing slots, one down-counter each
    localparam int GAP_RCD  = 0;  // open -> column
    localparam int GAP_RAS  = 1;  // open -> close
    localparam int GAP_RC   = 2;  // open -> open
    localparam int GAP_RP   = 3;  // close -> open
    localparam int GAP_WREC = 4;  // write -> close
    localparam int GAP_WACT = 5;  // write -> open
    localparam int NUM_GAPS = 6;

    // whole clocks covering a nanosecond figure (rounded up)
    function automatic int ns_to_clk(input int ns, input int tck_ps);
        return (ns * 1000 + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int W   = 8,
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int LOADV = (LEN > 1) ? LEN - 1 : 0;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= W'(LOADV);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R1: without a reload the remaining spacing only shrinks
    p_no_rise_r1: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/sdram_open_watch.sv
module sdram_open_watch #(
    parameter int MAXC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic open_start,
    input  logic row_open,
    output logic viol
);
    localparam int AW = $clog2(MAXC + 1) + 1;

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age  <= '0;
            viol <= 1'b0;
        end else begin
            if (open_start)
                age <= '0;
            else if (row_open && age != AW'(MAXC))
                age <= age + 1'b1;
            if (row_open && age == AW'(MAXC))
                viol <= 1'b1;
        end
    end

    p_age_cap_r11: assert property (@(posedge clk) disable iff (rst)
        age <= AW'(MAXC));

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int TCK_PS        = 4000,
    parameter int T_RCD_NS      = 15,
    parameter int T_RAS_NS      = 42,
    parameter int T_RAS_MAX_NS  = 100000,
    parameter int T_RC_NS       = 60,
    parameter int T_RP_NS       = 15,
    parameter int T_WACT_RLX_NS = 20,
    parameter int BURST_LEN     = 4,
    parameter bit RELAX_WR      = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       cmd_ready,
    output logic [2:0] cmd_out,
    output logic       proto_err,
    output logic       tras_violation
);
    localparam bit RELAX_OK = RELAX_WR && (TCK_PS >= 10000);
    localparam int C_RCD  = ns_to_clk(T_RCD_NS, TCK_PS);
    localparam int C_RAS  = ns_to_clk(T_RAS_NS, TCK_PS);
    localparam int C_RC   = ns_to_clk(T_RC_NS, TCK_PS);
    localparam int C_RP   = ns_to_clk(T_RP_NS, TCK_PS);
    localparam int C_MAX  = ns_to_clk(T_RAS_MAX_NS, TCK_PS);
    localparam int C_RDL  = RELAX_OK ? 1 : 2;
    localparam int C_DAL  = RELAX_OK ? 1 + ns_to_clk(T_WACT_RLX_NS, TCK_PS) : 2 + C_RP;
    localparam int GAP_LEN [NUM_GAPS] = '{
        C_RCD, C_RAS, C_RC, C_RP, BURST_LEN - 1 + C_RDL, BURST_LEN - 1 + C_DAL
    };
    localparam int CW = $clog2(C_RC + C_RAS + C_RCD + C_DAL + BURST_LEN + 2) + 1;

    cmd_e                req;
    cmd_e                cmd_q;
    cmd_e                fwd;
    logic                row_open;
    logic                perr_q;
    logic                ok;
    logic                reject;
    logic                fire;
    logic [NUM_GAPS-1:0] gap_done;
    logic [NUM_GAPS-1:0] gap_load;

    assign req = cmd_e'(cmd_code);

    // admission: protocol check first, then the spacings that apply
    always_comb begin
        ok     = 1'b1;
        reject = 1'b0;
        fwd    = CMD_NOP;
        case (req)
            CMD_ACT: begin
                fwd = CMD_ACT;
                if (row_open) reject = 1'b1;
                else ok = gap_done[GAP_RC] & gap_done[GAP_RP] & gap_done[GAP_WACT];
            end
            CMD_RD, CMD_WR: begin
                fwd = req;
                if (!row_open) reject = 1'b1;
                else ok = gap_done[GAP_RCD];
            end
            CMD_PRE: begin
                fwd = CMD_PRE;
                ok  = gap_done[GAP_RAS] & gap_done[GAP_WREC];
            end
            CMD_BST: fwd = CMD_BST;
            default: fwd = CMD_NOP;
        endcase
    end

    assign cmd_ready = ok | reject;
    assign fire      = cmd_valid && cmd_ready && !reject;

    always_comb begin
        gap_load           = '0;
        gap_load[GAP_RCD]  = fire && (req == CMD_ACT);
        gap_load[GAP_RAS]  = fire && (req == CMD_ACT);
        gap_load[GAP_RC]   = fire && (req == CMD_ACT);
        gap_load[GAP_RP]   = fire && (req == CMD_PRE);
        gap_load[GAP_WREC] = fire && (req == CMD_WR);
        gap_load[GAP_WACT] = fire && (req == CMD_WR);
    end

    for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
        sdram_gap_timer #(
            .W   (CW),
            .LEN (GAP_LEN[g])
        ) u_timer (
            .clk  (clk),
            .rst  (rst),
            .load (gap_load[g]),
            .done (gap_done[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            row_open <= 1'b0;
            perr_q   <= 1'b0;
        end else begin
            cmd_q  <= fire ? fwd : CMD_NOP;
            perr_q <= cmd_valid && reject;
            if (fire && req == CMD_ACT)
                row_open <= 1'b1;
            else if (fire && req == CMD_PRE)
                row_open <= 1'b0;
        end
    end

    sdram_open_watch #(
        .MAXC (C_MAX)
    ) u_watch (
        .clk        (clk),
        .rst        (rst),
        .open_start (fire && req == CMD_ACT),
        .row_open   (row_open),
        .viol       (tras_violation)
    );

    assign cmd_out   = cmd_q;
    assign proto_err = perr_q;

    p_col_open_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> row_open);

    p_act_fresh_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |-> (row_open && !$past(row_open)));

    p_err_nop_r10: assert property (@(posedge clk) disable iff (rst)
        perr_q |-> (cmd_q == CMD_NOP));

    p_pre_shuts_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE) |-> !row_open);

endmodule

// File: tb/sim_sdram_cmd_guard.sv
`timescale 1ns/1ps
module sim_sdram_cmd_guard;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;
    localparam int MAXC = 50;  // 200 ns at 4 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       v    [2];
    logic [2:0] cd   [2];
    logic       rdy  [2];
    logic [2:0] co   [2];
    logic       perr [2];
    logic       viol [2];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // strict: 4 ns clock, relaxed requested but not allowed
    sdram_cmd_guard #(
        .TCK_PS(4000), .T_RC_NS(68), .T_RAS_MAX_NS(200), .RELAX_WR(1'b1)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_valid(v[0]), .cmd_code(cd[0]),
        .cmd_ready(rdy[0]), .cmd_out(co[0]), .proto_err(perr[0]),
        .tras_violation(viol[0])
    );

    // relaxed: 10 ns clock figures
    sdram_cmd_guard #(
        .TCK_PS(10000), .T_RC_NS(68), .RELAX_WR(1'b1)
    ) u1 (
        .clk(clk), .rst(rst), .cmd_valid(v[1]), .cmd_code(cd[1]),
        .cmd_ready(rdy[1]), .cmd_out(co[1]), .proto_err(perr[1]),
        .tras_violation(viol[1])
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // offer a command; returns the cycle index of its grant edge
    task automatic send(input int u, input logic [2:0] c, output int g);
        v[u] = 1'b1;
        cd[u] = c;
        #1;
        while (!rdy[u]) begin
            @(negedge clk);
            #1;
        end
        g = cyc;
        @(negedge clk);
        v[u] = 1'b0;
        cd[u] = NOP;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 reset cmd_out", co[0], NOP);
        check("R11 reset violation", viol[0], 0);
        check("R10 reset proto_err", perr[0], 0);
        cd[0] = ACT;
        #1;
        check("R12 reset open ready", rdy[0], 1);
        cd[0] = NOP;
        @(negedge clk);
    endtask

    task automatic t_row_spacing;
        int g0, g1, g2, g3, g4, g5;
        send(0, ACT, g0);
        check("R12 cmd_out ACT", co[0], ACT);
        send(0, RD, g1);
        check("R2 R1 tRCD gap", g1 - g0, 4);
        check("R12 cmd_out READ", co[0], RD);
        send(0, PRE, g2);
        check("R3 R1 tRAS gap 42ns->11", g2 - g0, 11);
        send(0, ACT, g3);
        check("R4 tRC gap", g3 - g0, 17);
        idle(25);
        send(0, PRE, g4);
        send(0, ACT, g5);
        check("R5 tRP gap", g5 - g4, 4);
        idle(12);
        send(0, PRE, g4);
        idle(6);
    endtask

    task automatic t_write_recovery(input int u, input int e_rec, input int e_act, input string tag);
        int ga, gw, gp, gb;
        send(u, ACT, ga);
        idle(8);
        send(u, WR, gw);
        send(u, PRE, gp);
        check({tag, " R6 write->close"}, gp - gw, e_rec);
        send(u, ACT, gb);
        check({tag, " R7 write->open"}, gb - gw, e_act);
        idle(20);
        send(u, PRE, gp);
        idle(20);
    endtask

    task automatic t_columns;
        int ga, g1, g2, g3, g4, gp;
        send(0, ACT, ga);
        send(0, RD, g1);
        send(0, RD, g2);
        send(0, WR, g3);
        check("R12 cmd_out WRITE", co[0], WR);
        send(0, RD, g4);
        check("R9 read->read", g2 - g1, 1);
        check("R9 read->write", g3 - g2, 1);
        check("R9 write->read", g4 - g3, 1);
        send(0, PRE, gp);
        idle(20);
    endtask

    task automatic t_protocol;
        int g, ga, gr, gp;
        send(0, RD, g);
        check("R10 closed read not forwarded", co[0], NOP);
        check("R10 closed read error", perr[0], 1);
        idle(1);
        check("R10 error one cycle", perr[0], 0);
        send(0, ACT, ga);
        idle(20);
        send(0, ACT, g);
        check("R10 double open not forwarded", co[0], NOP);
        check("R10 double open error", perr[0], 1);
        send(0, RD, gr);
        check("R10 no reload after reject", gr - g, 1);
        check("R10 read forwarded", co[0], RD);
        send(0, 3'd6, g);
        check("R12 unknown code as NOP", co[0], NOP);
        send(0, PRE, gp);
        idle(20);
    endtask

    task automatic t_overstay;
        int ga, gp;
        send(0, ACT, ga);
        while (cyc != ga + MAXC) @(negedge clk);
        send(0, PRE, gp);
        check("R11 close at limit granted", gp - ga, MAXC);
        idle(2);
        check("R11 close at limit no flag", viol[0], 0);
        idle(20);
        send(0, ACT, ga);
        while (cyc != ga + MAXC + 1) @(negedge clk);
        check("R11 flag low at limit", viol[0], 0);
        @(negedge clk);
        check("R11 flag high past limit", viol[0], 1);
        send(0, PRE, gp);
        idle(3);
        check("R11 flag sticky", viol[0], 1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R11 flag cleared by reset", viol[0], 0);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            v[i] = 1'b0;
            cd[i] = NOP;
        end
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_row_spacing();
        t_write_recovery(0, 5, 9, "R8 strict at 4ns");
        t_write_recovery(1, 4, 6, "R8 relaxed at 10ns");
        t_columns();
        t_protocol();
        t_overstay();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule